// File: doc/BRIEF.md
# GPIO Bank with Atomic Set/Clear Aliases

This block is a memory-mapped general-purpose I/O controller for a configurable number of pins. Software programs it through one 32-bit register port that has an address, a write enable, write data and read data. The pins are grouped in 32-bit words. There are four banks: pin direction, output level, sampled input level and a 4-bit function-select (mode) field for each pin. Every word that software can write has three write addresses. The first replaces the whole word. The second ORs bits into the word. The third clears bits in the word. Two agents can therefore change separate pins without a read-modify-write race.

On the pin side the block drives an output-enable vector, an output-level vector and a packed vector of mode fields. It takes a raw input vector and resynchronises it into the clock domain before software can read it. Reads are combinational from the address. Writes take effect at the clock edge on which the write enable is sampled. The reset is asynchronous and active-low. Its release passes through a two-flop synchronizer.

Top module: `gpio_alias_bank`

## Requirements
- R1: When reset is asserted, every direction, output and mode bit is 0. Every pin is then an input (pin_oe all 0), pin_out is all 0 and every mode field is 0.
- R2: Address bits [9:8] select the bank: 0 is direction at 0x000, 1 is output at 0x100, 2 is input at 0x200 and 3 is mode at 0x300. Pin n sits in group n/32, at bit n%32, and group g sits at bank base + 0x10*g.
- R3: A write to a word's base address (offset +0x0) replaces the word. A read of offset +0x0 returns the word.
- R4: A write to the word's offset +0x4 ORs the write data into the word.
- R5: A write to the word's offset +0x8 clears each bit that is 1 in the write data and leaves the other bits as they were.
- R6: Direction bit n drives pin_oe[n], where 1 makes the pin an output. Output bit n drives pin_out[n].
- R7: Pin p has a 4-bit mode field in mode word p/8, at bits 4*(p%8)+3 down to 4*(p%8). This field appears on pin_mode[4p+3:4p].
- R8: Reads of the input bank return pin_in through a two-flop synchronizer. A change in pin_in that is set up before edge k can be read after edge k+1 and not before.
- R9: The input bank ignores writes at all three write offsets.
- R10: Reads of an unmapped address return 0, and writes to it change nothing. Unmapped means a low nibble other than 0x0 (reads) or other than 0x0, 0x4 or 0x8 (writes), a group or mode word beyond the pin count, or any address bit above bit 9 set.
- R11: Bits for pins that do not exist in the last word of a bank read as 0 and cannot be set.
- R12: A write changes the pin outputs at the rising edge that samples bus_we, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | NUM_PINS | Raw pin levels from the pads |
| pin_oe | output | NUM_PINS | Output enable per pin (direction bank) |
| pin_out | output | NUM_PINS | Output level per pin |
| pin_mode | output | 4*NUM_PINS | Packed 4-bit mode field per pin |

## Verification
The hardest case is the last, partly filled word of a bank. With the default 40 pins, group 1 holds only 8 real pins. The bench writes all ones there through both the plain address and the set alias. It then checks that only the low byte reads back and reaches the pins. The bench also tests out-of-range groups and addresses with bit 10 set. These addresses alias a live word in their low bits, so a decoder that drops the upper bits would hit real state and fail the check. The bench times the synchronizer by changing pin_in between edges and reading the input bank after one edge and again after two.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;

  localparam int WORD_W      = 32;
  localparam int MODE_W      = 4;
  localparam int MODES_PER_W = WORD_W / MODE_W;

  typedef enum logic [1:0] {
    BANK_DIR  = 2'd0,
    BANK_OUT  = 2'd1,
    BANK_IN   = 2'd2,
    BANK_MODE = 2'd3
  } bank_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } op_e;

  typedef struct packed {
    logic       hit;
    bank_e      bank;
    logic [3:0] word;
    op_e        op;
  } dec_t;

  // Bits of word word_idx that hold real state, given total_bits of state.
  function automatic logic [WORD_W-1:0] valid_mask(input int total_bits, input int word_idx);
    int remain;
    remain = total_bits - word_idx * WORD_W;
    if (remain >= WORD_W)  return '1;
    else if (remain <= 0)  return '0;
    else                   return (32'h1 << remain) - 32'h1;
  endfunction

endpackage

// File: rtl/gpio_alias_decode.sv
module gpio_alias_decode
  import gpio_alias_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);

  logic upper_zero;
  op_e  op_n;

  always_comb begin
    upper_zero = ((addr >> 10) == '0);
    case (addr[3:0])
      4'h0:    op_n = OP_WRITE;
      4'h4:    op_n = OP_SET;
      4'h8:    op_n = OP_CLEAR;
      default: op_n = OP_NONE;
    endcase
    dec.hit  = upper_zero && (op_n != OP_NONE);
    dec.bank = bank_e'(addr[9:8]);
    dec.word = addr[7:4];
    dec.op   = op_n;
  end

endmodule

// File: rtl/gpio_alias_word.sv
module gpio_alias_word
  import gpio_alias_pkg::*;
#(
  parameter int              W    = 32,
  parameter logic [W-1:0]    MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  op_e          op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic         en;
  logic [W-1:0] d;

  always_comb begin
    en = sel && (op != OP_NONE);
    case (op)
      OP_WRITE: d = wdata;
      OP_SET:   d = q | wdata;
      OP_CLEAR: d = q & ~wdata;
      default:  d = q;
    endcase
    d = d & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] synced
);

  logic [N-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      synced <= '0;
    end else begin
      stage1 <= raw;
      synced <= stage1;
    end
  end

endmodule

// File: rtl/gpio_alias_bank.sv
module gpio_alias_bank
  import gpio_alias_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_we,
  input  logic [WORD_W-1:0]          bus_wdata,
  output logic [WORD_W-1:0]          bus_rdata,
  input  logic [NUM_PINS-1:0]        pin_in,
  output logic [NUM_PINS-1:0]        pin_oe,
  output logic [NUM_PINS-1:0]        pin_out,
  output logic [NUM_PINS*MODE_W-1:0] pin_mode
);

  localparam int GROUPS     = (NUM_PINS + WORD_W - 1) / WORD_W;
  localparam int MODE_BITS  = NUM_PINS * MODE_W;
  localparam int MODE_WORDS = (NUM_PINS + MODES_PER_W - 1) / MODES_PER_W;
  localparam int DATA_PAD   = GROUPS * WORD_W;
  localparam int MODE_PAD   = MODE_WORDS * WORD_W;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  dec_t dec;

  gpio_alias_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  logic [DATA_PAD-1:0] dir_q;
  logic [DATA_PAD-1:0] out_q;
  logic [MODE_PAD-1:0] mode_q;
  logic [NUM_PINS-1:0] in_sync;
  logic [DATA_PAD-1:0] in_pad;

  for (genvar g = 0; g < GROUPS; g++) begin : g_data
    gpio_alias_word #(.W(WORD_W), .MASK(valid_mask(NUM_PINS, g))) u_dir (
      .clk   (clk),
      .rst_n (rst_q),
      .sel   (bus_we && dec.hit && dec.bank == BANK_DIR && dec.word == 4'(g)),
      .op    (dec.op),
      .wdata (bus_wdata),
      .q     (dir_q[g*WORD_W +: WORD_W])
    );
    gpio_alias_word #(.W(WORD_W), .MASK(valid_mask(NUM_PINS, g))) u_out (
      .clk   (clk),
      .rst_n (rst_q),
      .sel   (bus_we && dec.hit && dec.bank == BANK_OUT && dec.word == 4'(g)),
      .op    (dec.op),
      .wdata (bus_wdata),
      .q     (out_q[g*WORD_W +: WORD_W])
    );
  end

  for (genvar k = 0; k < MODE_WORDS; k++) begin : g_mode
    gpio_alias_word #(.W(WORD_W), .MASK(valid_mask(MODE_BITS, k))) u_mode (
      .clk   (clk),
      .rst_n (rst_q),
      .sel   (bus_we && dec.hit && dec.bank == BANK_MODE && dec.word == 4'(k)),
      .op    (dec.op),
      .wdata (bus_wdata),
      .q     (mode_q[k*WORD_W +: WORD_W])
    );
  end

  gpio_in_sync #(.N(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_q),
    .raw    (pin_in),
    .synced (in_sync)
  );

  assign in_pad = DATA_PAD'(in_sync);

  // Read path: only plain offsets of existing words return data.
  always_comb begin
    bus_rdata = '0;
    if (dec.hit && dec.op == OP_WRITE) begin
      case (dec.bank)
        BANK_DIR: begin
          for (int i = 0; i < GROUPS; i++)
            if (dec.word == i[3:0]) bus_rdata = dir_q[i*WORD_W +: WORD_W];
        end
        BANK_OUT: begin
          for (int i = 0; i < GROUPS; i++)
            if (dec.word == i[3:0]) bus_rdata = out_q[i*WORD_W +: WORD_W];
        end
        BANK_IN: begin
          for (int i = 0; i < GROUPS; i++)
            if (dec.word == i[3:0]) bus_rdata = in_pad[i*WORD_W +: WORD_W];
        end
        default: begin
          for (int i = 0; i < MODE_WORDS; i++)
            if (dec.word == i[3:0]) bus_rdata = mode_q[i*WORD_W +: WORD_W];
        end
      endcase
    end
  end

  assign pin_oe   = dir_q[NUM_PINS-1:0];
  assign pin_out  = out_q[NUM_PINS-1:0];
  assign pin_mode = mode_q[MODE_BITS-1:0];

endmodule

// File: rtl/gpio_alias_bank_chk.sv
module gpio_alias_bank_chk #(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 12
) (
  input logic                  clk,
  input logic                  rst_q,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_we,
  input logic [31:0]           bus_wdata,
  input logic [31:0]           bus_rdata,
  input logic [NUM_PINS-1:0]   pin_oe,
  input logic [NUM_PINS-1:0]   pin_out,
  input logic [NUM_PINS*4-1:0] pin_mode
);

  localparam int G0 = (NUM_PINS < 32) ? NUM_PINS : 32;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(rst_q) |-> (pin_oe == '0 && pin_out == '0 && pin_mode == '0));

  // R3
  plain_write_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr == ADDR_W'('h000)) |=> (pin_oe[G0-1:0] == $past(bus_wdata[G0-1:0])));

  // R4
  set_alias_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr == ADDR_W'('h004)) |=>
      ((pin_oe[G0-1:0] & $past(bus_wdata[G0-1:0])) == $past(bus_wdata[G0-1:0])));

  // R5
  clear_alias_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr == ADDR_W'('h108)) |=> ((pin_out[G0-1:0] & $past(bus_wdata[G0-1:0])) == '0));

  // R9
  in_bank_ignore_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr[9:8] == 2'b10) |=> ($stable(pin_oe) && $stable(pin_out) && $stable(pin_mode)));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !bus_we |=> ($stable(pin_oe) && $stable(pin_out) && $stable(pin_mode)));

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_addr[3:0] != 4'h0) |-> (bus_rdata == 32'h0));

endmodule

bind gpio_alias_bank gpio_alias_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .pin_mode  (pin_mode)
);

// File: tb/tb_gpio_alias_bank.sv
module tb_gpio_alias_bank;

  localparam int N = 40;

  logic          clk;
  logic          rst_n;
  logic [11:0]   addr;
  logic          we;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic [N-1:0]  pin_in;
  logic [N-1:0]  pin_oe;
  logic [N-1:0]  pin_out;
  logic [4*N-1:0] pin_mode;

  int tests;
  int fails;
  logic done;

  gpio_alias_bank #(.NUM_PINS(N), .ADDR_W(12)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (addr),
    .bus_we    (we),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .pin_in    (pin_in),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .pin_mode  (pin_mode)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 12'h000; wdata = 32'h0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    check("R1 pin_oe", 64'(pin_oe), 64'h0);
    check("R1 pin_out", 64'(pin_out), 64'h0);
    check("R1 pin_mode", 64'(pin_mode[63:0]), 64'h0);
    bus_read(12'h000, r);
    check("R1 dir read", 64'(r), 64'h0);
  endtask

  task automatic t_dir_word();
    logic [31:0] r;
    bus_write(12'h000, 32'hA5A5_00FF);
    check("R3/R6 pin_oe after write", 64'(pin_oe[31:0]), 64'hA5A5_00FF);
    bus_read(12'h000, r);
    check("R3 dir readback", 64'(r), 64'hA5A5_00FF);
  endtask

  task automatic t_set_clear();
    logic [31:0] r;
    bus_write(12'h004, 32'h0F00_0000);
    check("R4 set alias", 64'(pin_oe[31:0]), 64'hAFA5_00FF);
    bus_write(12'h008, 32'h0000_000F);
    check("R5 clear alias", 64'(pin_oe[31:0]), 64'hAFA5_00F0);
    bus_read(12'h000, r);
    check("R5 readback", 64'(r), 64'hAFA5_00F0);
  endtask

  task automatic t_partial_group();
    logic [31:0] r;
    bus_write(12'h010, 32'hFFFF_FFFF);
    check("R2 group1 pins", 64'(pin_oe), 64'hFF_AFA5_00F0);
    bus_read(12'h010, r);
    check("R11 partial word read", 64'(r), 64'h0000_00FF);
    bus_write(12'h014, 32'hFFFF_0000);
    bus_read(12'h010, r);
    check("R11 set of missing bits", 64'(r), 64'h0000_00FF);
  endtask

  task automatic t_out_bank();
    logic [31:0] r;
    bus_write(12'h100, 32'h1234_5678);
    bus_write(12'h114, 32'h0000_0081);
    bus_write(12'h118, 32'h0000_0001);
    check("R6 pin_out", 64'(pin_out), 64'h80_1234_5678);
    bus_read(12'h110, r);
    check("R2 out group1 read", 64'(r), 64'h0000_0080);
  endtask

  task automatic t_mode();
    logic [31:0] r;
    bus_write(12'h300, 32'h7654_3210);
    check("R7 pin3 mode", 64'(pin_mode[15:12]), 64'h3);
    bus_write(12'h308, 32'h0000_0030);
    check("R7 mode clear", 64'(pin_mode[31:0]), 64'h7654_3200);
    bus_write(12'h344, 32'h0000_0005);
    check("R7 pin32 mode", 64'(pin_mode[131:128]), 64'h5);
    bus_read(12'h340, r);
    check("R7 mode word4 read", 64'(r), 64'h0000_0005);
  endtask

  task automatic t_input_sync();
    logic [31:0] r;
    @(negedge clk);
    pin_in = 40'hA5_1234_5678;
    @(negedge clk);
    bus_read(12'h200, r);
    check("R8 after one edge", 64'(r), 64'h0);
    @(negedge clk);
    bus_read(12'h200, r);
    check("R8 after two edges", 64'(r), 64'h1234_5678);
    bus_read(12'h210, r);
    check("R8 group1 input", 64'(r), 64'h0000_00A5);
  endtask

  task automatic t_input_ignore();
    logic [31:0] r;
    bus_write(12'h200, 32'h0);
    bus_write(12'h204, 32'hFFFF_FFFF);
    bus_write(12'h208, 32'hFFFF_FFFF);
    bus_read(12'h200, r);
    check("R9 input unaffected", 64'(r), 64'h1234_5678);
    check("R9 pin_oe unaffected", 64'(pin_oe), 64'hFF_AFA5_00F0);
    check("R9 pin_out unaffected", 64'(pin_out), 64'h80_1234_5678);
  endtask

  task automatic t_unmapped();
    logic [31:0] r;
    bus_read(12'h004, r);
    check("R10 alias read zero", 64'(r), 64'h0);
    bus_write(12'h00C, 32'h0);
    bus_write(12'h020, 32'h0);
    bus_write(12'h400, 32'h0);
    check("R10 dir unchanged", 64'(pin_oe), 64'hFF_AFA5_00F0);
    bus_read(12'h020, r);
    check("R10 group2 read zero", 64'(r), 64'h0);
    bus_read(12'h400, r);
    check("R10 upper-bit read zero", 64'(r), 64'h0);
    bus_write(12'h350, 32'hFFFF_FFFF);
    check("R10 mode unchanged", 64'(pin_mode[31:0]), 64'h7654_3200);
    bus_read(12'h350, r);
    check("R10 mode word5 zero", 64'(r), 64'h0);
  endtask

  task automatic t_timing();
    @(negedge clk);
    addr = 12'h000; we = 1'b1; wdata = 32'h0;
    #1;
    check("R12 before edge", 64'(pin_oe[31:0]), 64'hAFA5_00F0);
    @(posedge clk);
    #1;
    check("R12 after edge", 64'(pin_oe), 64'hFF_0000_0000);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic t_rereset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async oe clear", 64'(pin_oe), 64'h0);
    check("R1 async out clear", 64'(pin_out), 64'h0);
    check("R1 async mode clear", 64'(pin_mode[159:96]), 64'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0;
    fails = 0;
    pin_in = '0;
    do_reset();
    t_reset();
    t_dir_word();
    t_set_clear();
    t_partial_group();
    t_out_bank();
    t_mode();
    t_input_sync();
    t_input_ignore();
    t_unmapped();
    t_timing();
    t_rereset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule